// File: doc/BRIEF.md
# Per-Port Power Disconnect Timer

This block decides when a powered port has lost its load and should have its power removed. Each port has two independent ways of sensing that a load is still present. One is a DC indication that the port current is above its minimum. The other is an AC indication that the sensed impedance current is above its minimum. Software turns each method on or off per port through one configuration register. While a port is powered and at least one of its methods is enabled, a per-port counter measures how long the port has gone without any enabled keep-alive. When that time passes the disconnect window, the block emits a one-cycle turn-off request for that port.

The enabled keep-alive indications are ORed, so either method alone keeps a port powered. A port with both methods disabled never asks to be turned off. The block ignores any oscillator-fail status, because it takes no such input. The disconnect window is the parameter `TDIS_CYCLES`, counted in clock cycles. The measurement and the excitation circuitry stay outside the block.

Top module: `pwr_disc_timer`

## Requirements
- R1: The enable register resets to all zeros. When `cfg_wr_en` is high at a clock edge, it loads `cfg_wdata`, and `cfg_rdata` shows the new value from the following cycle. Bit i (i < NUM_PORTS) is the DC enable of port i, and bit NUM_PORTS+i is the AC enable of port i.
- R2: A port that is powered and has DC enabled, and that sees no enabled keep-alive on TDIS_CYCLES+1 consecutive clock edges, raises `off_req` for that port in the cycle after the last of those edges.
- R3: A port with only AC enabled behaves as in R2, with `ac_alive` as its keep-alive. `ac_alive` held high keeps the port from ever being turned off.
- R4: Any enabled keep-alive that is high at an edge restarts the count from zero. A keep-alive that is low for exactly TDIS_CYCLES edges and then high produces no request.
- R5: A keep-alive input whose method is disabled has no effect. For example, `dc_alive` held high on a port with only AC enabled does not delay its request.
- R6: A powered port with both enables clear never raises `off_req`, however long both keep-alives stay low.
- R7: Each expiry gives exactly one single-cycle `off_req` pulse. After a pulse, no further request is made for that port until `port_on` has been low for at least one edge and then the port is powered again.
- R8: While `port_on` is low, the port's counter is held at zero and `off_req` stays low. A freshly powered port needs a full window before it can expire.
- R9: Clearing an enable bit takes effect at the write edge. A port left with no enabled method clears its count, and after re-enabling it needs a full new window. Clearing the AC bit of a port kept alive only by AC starts the DC window at once.
- R10: While `rst_n` is low, all `off_req` outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Write strobe for the enable register |
| cfg_wdata | input | 2*NUM_PORTS | Enable register write data (low half DC, high half AC) |
| cfg_rdata | output | 2*NUM_PORTS | Current contents of the enable register |
| port_on | input | NUM_PORTS | Port is powered |
| dc_alive | input | NUM_PORTS | DC current above minimum, per port |
| ac_alive | input | NUM_PORTS | AC sense current above minimum, per port |
| off_req | output | NUM_PORTS | One-cycle request to remove power, per port |

## Verification
The hardest situation to reach from the ports is an enable change in the middle of a running window. The case of interest is a port that is partly through its count, or is kept alive only by its AC method, when software rewrites the enable register. The stimulus starves a port for part of a window, clears or narrows its enables with a register write, and then re-enables it. A behavioural reference model runs alongside and shows whether the request lands exactly one full window after the change. The stimulus also places a keep-alive on the very last edge before expiry, to pin down the off-by-one boundary of the window.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  // Life cycle of one port's disconnect timer.
  typedef enum logic [0:0] {
    TMR_LIVE  = 1'b0,   // powered or idle, may count starved cycles
    TMR_SPENT = 1'b1    // request already issued, waiting for power off
  } tmr_state_e;

endpackage

// File: rtl/pdt_rst_sync.sv
module pdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pdt_enable_reg.sv
module pdt_enable_reg #(
  parameter int NUM_PORTS = 4,
  localparam int RW = 2 * NUM_PORTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [RW-1:0]        wdata,
  output logic [RW-1:0]        rdata,
  output logic [NUM_PORTS-1:0] dc_en,
  output logic [NUM_PORTS-1:0] ac_en
);

  logic [RW-1:0] en_q;
  logic [RW-1:0] en_d;
  logic          en_ce;

  always_comb begin
    en_ce = wr_en;
    en_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  assign rdata = en_q;
  assign dc_en = en_q[NUM_PORTS-1:0];
  assign ac_en = en_q[RW-1:NUM_PORTS];

endmodule

// File: rtl/pdt_keepalive.sv
module pdt_keepalive #(
  parameter int NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0] dc_en,
  input  logic [NUM_PORTS-1:0] ac_en,
  input  logic [NUM_PORTS-1:0] dc_alive,
  input  logic [NUM_PORTS-1:0] ac_alive,
  output logic [NUM_PORTS-1:0] keep,
  output logic [NUM_PORTS-1:0] armed
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic dc_hit;
    logic ac_hit;
    always_comb begin
      dc_hit   = dc_en[p] & dc_alive[p];
      ac_hit   = ac_en[p] & ac_alive[p];
      keep[p]  = dc_hit | ac_hit;
      armed[p] = dc_en[p] | ac_en[p];
    end
  end

endmodule

// File: rtl/pdt_port_timer.sv
module pdt_port_timer
  import pdt_pkg::*;
#(
  parameter int TDIS_CYCLES = 3000,
  localparam int CW = $clog2(TDIS_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_on,
  input  logic          keep,
  input  logic          armed,
  output logic          off_req,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LIMIT = CW'(TDIS_CYCLES);

  tmr_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          req_q, req_d;
  logic          starved;
  logic          expire;

  always_comb begin
    starved = port_on & armed & ~keep;
    expire  = starved & (cnt_q == LIMIT);
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (!port_on) begin
      st_d  = TMR_LIVE;
      cnt_d = '0;
    end else begin
      case (st_q)
        TMR_LIVE: begin
          if (!starved) begin
            cnt_d = '0;
          end else if (expire) begin
            req_d = 1'b1;
            st_d  = TMR_SPENT;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        TMR_SPENT: begin
          cnt_d = '0;
        end
        default: begin
          st_d  = TMR_LIVE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TMR_LIVE;
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign off_req = req_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/pwr_disc_timer.sv
module pwr_disc_timer #(
  parameter int NUM_PORTS   = 4,
  parameter int TDIS_CYCLES = 3000,
  localparam int RW = 2 * NUM_PORTS,
  localparam int CW = $clog2(TDIS_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [RW-1:0]        cfg_wdata,
  output logic [RW-1:0]        cfg_rdata,
  input  logic [NUM_PORTS-1:0] port_on,
  input  logic [NUM_PORTS-1:0] dc_alive,
  input  logic [NUM_PORTS-1:0] ac_alive,
  output logic [NUM_PORTS-1:0] off_req
);

  logic                    rst_n_int;
  logic [NUM_PORTS-1:0]    dc_en_w;
  logic [NUM_PORTS-1:0]    ac_en_w;
  logic [NUM_PORTS-1:0]    keep_w;
  logic [NUM_PORTS-1:0]    armed_w;
  logic [NUM_PORTS*CW-1:0] cnt_all;

  pdt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pdt_enable_reg #(.NUM_PORTS(NUM_PORTS)) u_en (
    .clk   (clk),
    .rst_n (rst_n_int),
    .wr_en (cfg_wr_en),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .dc_en (dc_en_w),
    .ac_en (ac_en_w)
  );

  pdt_keepalive #(.NUM_PORTS(NUM_PORTS)) u_ka (
    .dc_en    (dc_en_w),
    .ac_en    (ac_en_w),
    .dc_alive (dc_alive),
    .ac_alive (ac_alive),
    .keep     (keep_w),
    .armed    (armed_w)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_tmr
    pdt_port_timer #(.TDIS_CYCLES(TDIS_CYCLES)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .port_on (port_on[p]),
      .keep    (keep_w[p]),
      .armed   (armed_w[p]),
      .off_req (off_req[p]),
      .cnt_o   (cnt_all[p*CW +: CW])
    );
  end

endmodule

// File: rtl/pwr_disc_timer_chk.sv
module pwr_disc_timer_chk #(
  parameter int NUM_PORTS   = 4,
  parameter int TDIS_CYCLES = 3000,
  localparam int RW = 2 * NUM_PORTS,
  localparam int CW = $clog2(TDIS_CYCLES + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_wr_en,
  input logic [RW-1:0]           cfg_wdata,
  input logic [RW-1:0]           cfg_rdata,
  input logic [NUM_PORTS-1:0]    port_on,
  input logic [NUM_PORTS-1:0]    dc_alive,
  input logic [NUM_PORTS-1:0]    ac_alive,
  input logic [NUM_PORTS-1:0]    off_req,
  input logic [NUM_PORTS-1:0]    dc_en,
  input logic [NUM_PORTS-1:0]    ac_en,
  input logic [NUM_PORTS*CW-1:0] cnt_all
);

  AST_RDBACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> (cfg_rdata == $past(cfg_wdata))); // R1

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_all[p*CW +: CW] <= CW'(TDIS_CYCLES)); // R2

    AST_KEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (port_on[p] && ((dc_en[p] && dc_alive[p]) || (ac_en[p] && ac_alive[p])))
        |=> !off_req[p]); // R4

    AST_NO_EN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !(dc_en[p] || ac_en[p]) |=> !off_req[p]); // R6

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      off_req[p] |=> !off_req[p]); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !port_on[p] |=> (cnt_all[p*CW +: CW] == '0) && !off_req[p]); // R8
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (off_req == '0); // R10
    end
  end

endmodule

bind pwr_disc_timer pwr_disc_timer_chk #(
  .NUM_PORTS   (NUM_PORTS),
  .TDIS_CYCLES (TDIS_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr_en (cfg_wr_en),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .port_on   (port_on),
  .dc_alive  (dc_alive),
  .ac_alive  (ac_alive),
  .off_req   (off_req),
  .dc_en     (dc_en_w),
  .ac_en     (ac_en_w),
  .cnt_all   (cnt_all)
);

// File: tb/sim_pwr_disc_timer.sv
module sim_pwr_disc_timer;

  localparam int N = 4;
  localparam int T = 12;

  logic         clk;
  logic         rst_n;
  logic         cfg_wr_en;
  logic [7:0]   cfg_wdata;
  logic [7:0]   cfg_rdata;
  logic [N-1:0] port_on;
  logic [N-1:0] dc_alive;
  logic [N-1:0] ac_alive;
  logic [N-1:0] off_req;

  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  string tag    = "R10";
  int    pulses [N];

  // reference model state
  int         m_cnt   [N];
  bit         m_spent [N];
  logic [N-1:0] m_req;
  logic [7:0]   m_en;

  pwr_disc_timer #(.NUM_PORTS(N), .TDIS_CYCLES(T)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .port_on   (port_on),
    .dc_alive  (dc_alive),
    .ac_alive  (ac_alive),
    .off_req   (off_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural model of the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) begin
        m_cnt[p]   = 0;
        m_spent[p] = 0;
      end
      m_req = '0;
      m_en  = '0;
    end else begin
      for (int p = 0; p < N; p++) begin
        bit dce, ace, alive;
        dce      = m_en[p];
        ace      = m_en[N+p];
        alive    = (dce && dc_alive[p]) || (ace && ac_alive[p]);
        m_req[p] = 1'b0;
        if (!port_on[p]) begin
          m_cnt[p]   = 0;
          m_spent[p] = 0;
        end else if (m_spent[p]) begin
          m_cnt[p] = 0;
        end else if (alive || !(dce || ace)) begin
          m_cnt[p] = 0;
        end else if (m_cnt[p] == T) begin
          m_req[p]   = 1'b1;
          m_spent[p] = 1;
          m_cnt[p]   = 0;
        end else begin
          m_cnt[p] = m_cnt[p] + 1;
        end
      end
      if (cfg_wr_en) m_en = cfg_wdata;
    end
  end

  // Per-cycle comparison and pulse counting
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (off_req !== m_req) begin
        errors++;
        $display("FAIL %s off_req actual %b expected %b at %0t", tag, off_req, m_req, $time);
      end
      checks++;
      if (cfg_rdata !== m_en) begin
        errors++;
        $display("FAIL R1 cfg_rdata actual %h expected %h at %0t", cfg_rdata, m_en, $time);
      end
      for (int p = 0; p < N; p++) if (off_req[p] === 1'b1) pulses[p]++;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_pulses();
    for (int p = 0; p < N; p++) pulses[p] = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk(cfg_rdata == v, "R1 readback", int'(cfg_rdata), int'(v));
  endtask

  task automatic cycle_port(input int p);
    @(negedge clk);
    port_on[p] = 1'b0;
    @(negedge clk);
    port_on[p] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    cfg_wr_en = 1'b0;
    cfg_wdata = '0;
    port_on   = '0;
    dc_alive  = '0;
    ac_alive  = '0;
    clr_pulses();
    repeat (3) @(negedge clk);
    // R10 / R1: quiet outputs and cleared register during reset
    chk(off_req == '0, "R10 reset off_req", int'(off_req), 0);
    chk(cfg_rdata == '0, "R1 reset rdata", int'(cfg_rdata), 0);
    rst_n = 1'b1;
    wait_n(4);

    // R2: DC only on all ports, port 0 starved
    tag = "R2";
    wr(8'h0F);
    dc_alive = 4'b1110;
    port_on  = 4'b1111;
    clr_pulses();
    wait_n(3 * T);
    chk(pulses[0] == 1, "R7 one pulse port0", pulses[0], 1);
    chk(pulses[1] == 0, "R4 port1 kept", pulses[1], 0);

    // R4: keep-alive arriving on the last edge of the window
    tag = "R4";
    clr_pulses();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) dc_alive[1] = 1'b0;
      wait_n(T - 1);
      @(negedge clk) dc_alive[1] = 1'b1;
    end
    wait_n(2);
    chk(pulses[1] == 0, "R4 boundary", pulses[1], 0);

    // R3 / R5: AC only on port 2, DC alive ignored
    tag = "R3";
    wr(8'h4B);
    dc_alive[2] = 1'b1;
    ac_alive[2] = 1'b0;
    cycle_port(2);
    clr_pulses();
    wait_n(2 * T);
    chk(pulses[2] == 1, "R5 disabled dc_alive ignored", pulses[2], 1);
    ac_alive[2] = 1'b1;
    cycle_port(2);
    clr_pulses();
    wait_n(3 * T);
    chk(pulses[2] == 0, "R3 ac keep-alive", pulses[2], 0);

    // R6: port 3 with no method enabled
    tag = "R6";
    wr(8'h43);
    dc_alive[3] = 1'b0;
    ac_alive[3] = 1'b0;
    cycle_port(3);
    clr_pulses();
    wait_n(3 * T);
    chk(pulses[3] == 0, "R6 no enables", pulses[3], 0);

    // R7 / R8: spent port 0 stays quiet until power cycled
    tag = "R7";
    clr_pulses();
    wait_n(2 * T);
    chk(pulses[0] == 0, "R7 no repeat", pulses[0], 0);
    tag = "R8";
    @(negedge clk) port_on[0] = 1'b0;
    wait_n(2 * T);
    chk(pulses[0] == 0, "R8 unpowered", pulses[0], 0);
    port_on[0] = 1'b1;
    wait_n(T);
    chk(pulses[0] == 0, "R8 full window after power", pulses[0], 0);
    wait_n(T);
    chk(pulses[0] == 1, "R7 fires after repower", pulses[0], 1);

    // R9: clear the only enable mid-window, then re-enable
    tag = "R9";
    cycle_port(0);
    clr_pulses();
    wait_n(T / 2);
    wr(8'h42);
    wait_n(2 * T);
    chk(pulses[0] == 0, "R9 disabled mid-run", pulses[0], 0);
    wr(8'h43);
    wait_n(T);
    chk(pulses[0] == 0, "R9 fresh window", pulses[0], 0);
    wait_n(T);
    chk(pulses[0] == 1, "R9 expiry after re-enable", pulses[0], 1);

    // R9: AC was the only live method, clearing it starts the DC window
    wr(8'h53);
    ac_alive[0] = 1'b1;
    cycle_port(0);
    clr_pulses();
    wait_n(2 * T);
    chk(pulses[0] == 0, "R9 ac keeps", pulses[0], 0);
    wr(8'h43);
    wait_n(2 * T);
    chk(pulses[0] == 1, "R9 ac cleared", pulses[0], 1);

    wait_n(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule